// File: doc/BRIEF.md
# Next Program Counter Selection Unit

This block works out where instruction fetch goes next, for an instruction stream in which every instruction is 32 bits wide. For each instruction the decoder hands it the current program counter, a control class, a condition selector, up to two register operands, a 16-bit signed offset and a 26-bit jump field. The block then chooses the next fetch address and a taken indication.

The control class picks one of four behaviours. The instruction can simply fall through to the next word. It can be a conditional branch relative to the current address. It can be a jump to an absolute target inside the current 256 MB region. It can be a jump to an address held in a register, as used for returns and dynamic calls.

Conditions come in two groups. The first compares two registers for equality or inequality. The second looks only at the sign bit of one register and whether it is zero. Neither group needs a subtractor. Both results are registered when the instruction-valid strobe is high and held at all other times.

Top module: `nextpc_unit`

## Requirements
- R1: With class 0 (sequential), and with any undefined class 5, 6 or 7, the next PC is the current PC plus 4, wrapping modulo 2^32, and taken is 0.
- R2: With class 1 (register-pair branch), cond_sel bit 0 set to 0 takes the branch when opnd_a equals opnd_b. Set to 1, it takes the branch when they differ. cond_sel bit 1 has no effect for this class.
- R3: With class 2 (zero-test branch), cond_sel chooses the signed test on opnd_a: 00 is greater than zero, 01 is greater or equal to zero, 10 is less than zero, 11 is less or equal to zero.
- R4: A taken branch of class 1 or 2 goes to PC+4 plus the 16-bit offset, sign-extended and shifted left by two. Taken is 1.
- R5: Class 3 (absolute jump) goes to {(PC+4)[31:28], jump_field, 2'b00}, with taken 1. The region bits come from PC+4, not from PC.
- R6: Class 4 (register jump) goes to opnd_a with bits [1:0] forced to zero, with taken 1.
- R7: A branch of class 1 or 2 that is not taken gives PC+4 with taken 0.
- R8: While reset is asserted, and for the cycles before its synchronised release, next_pc reads 0 and taken reads 0.
- R9: When insn_valid is low, next_pc and taken keep their values whatever the other inputs do. Results appear on the clock edge that samples insn_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| insn_valid | input | 1 | Instruction strobe; outputs update on this cycle's edge |
| cur_pc | input | 32 | Address of the current instruction |
| ctl_class | input | 3 | 0 sequential, 1 register-pair branch, 2 zero-test branch, 3 absolute jump, 4 register jump |
| cond_sel | input | 2 | Branch condition selector |
| opnd_a | input | 32 | First register operand; also the jump source for class 4 |
| opnd_b | input | 32 | Second register operand |
| br_offset | input | 16 | Signed word offset for branches |
| jmp_field | input | 26 | Word index for absolute jumps |
| next_pc | output | 32 | Registered next fetch address |
| taken | output | 1 | Registered flag: control left the sequential path |

## Verification
On every cycle the bound checker confirms several behaviours:
- outputs hold while the strobe is low;
- sequential and undefined classes produce PC+4 with taken low;
- jumps always assert taken, and register jumps produce a word-aligned copy of the operand;
- an equality branch's taken flag matches the operand comparison;
- any untaken branch falls through to PC+4.

Only the bench scenarios show the exact target arithmetic: a negative offset, the most negative offset, the region carry when PC+4 crosses a 256 MB boundary, and address wrap. The same holds for each of the four zero-test codes at their sign and zero boundaries, and for the reset value after a mid-run reset.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  localparam int unsigned CLASS_W = 3;

  typedef enum logic [CLASS_W-1:0] {
    NPC_SEQ     = 3'd0,
    NPC_BR_PAIR = 3'd1,
    NPC_BR_ZERO = 3'd2,
    NPC_JMP_ABS = 3'd3,
    NPC_JMP_REG = 3'd4
  } npc_class_e;

  // zero-test condition codes (class NPC_BR_ZERO)
  localparam logic [1:0] ZT_GTZ = 2'b00;
  localparam logic [1:0] ZT_GEZ = 2'b01;
  localparam logic [1:0] ZT_LTZ = 2'b10;
  localparam logic [1:0] ZT_LEZ = 2'b11;
endpackage

// File: rtl/nextpc_cond.sv
// Branch decision: equality compare or sign/zero test, no subtractor.
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [CLASS_W-1:0] ctl_class,
  input  logic [1:0]         cond_sel,
  input  logic [XLEN-1:0]    opnd_a,
  input  logic [XLEN-1:0]    opnd_b,
  output logic               is_branch,
  output logic               br_take
);
  logic pair_eq;
  logic a_zero;
  logic a_neg;
  logic pair_take;
  logic zero_take;

  always_comb begin
    pair_eq = (opnd_a == opnd_b);
    a_zero  = ~|opnd_a;
    a_neg   = opnd_a[XLEN-1];

    pair_take = cond_sel[0] ? ~pair_eq : pair_eq;

    unique case (cond_sel)
      ZT_GTZ:  zero_take = ~a_neg & ~a_zero;
      ZT_GEZ:  zero_take = ~a_neg;
      ZT_LTZ:  zero_take = a_neg;
      default: zero_take = a_neg | a_zero;
    endcase

    is_branch = 1'b0;
    br_take   = 1'b0;
    if (ctl_class == NPC_BR_PAIR) begin
      is_branch = 1'b1;
      br_take   = pair_take;
    end else if (ctl_class == NPC_BR_ZERO) begin
      is_branch = 1'b1;
      br_take   = zero_take;
    end
  end
endmodule

// File: rtl/nextpc_target.sv
// Forms the three candidate targets plus the fall-through address.
module nextpc_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OFS_W = 16,
  parameter int unsigned JMP_W = 26,
  parameter int unsigned ILEN  = 4
) (
  input  logic [XLEN-1:0]       cur_pc,
  input  logic [OFS_W-1:0]      br_offset,
  input  logic [JMP_W-1:0]      jmp_field,
  input  logic [XLEN-1:$clog2(ILEN)] reg_word,
  output logic [XLEN-1:0]       seq_pc,
  output logic [XLEN-1:0]       br_pc,
  output logic [XLEN-1:0]       abs_pc,
  output logic [XLEN-1:0]       reg_pc
);
  localparam int unsigned SH    = $clog2(ILEN);
  localparam int unsigned EXT_W = XLEN - OFS_W - SH;
  localparam int unsigned RGN_W = XLEN - JMP_W - SH;

  logic [XLEN-1:0] ofs_ext;

  always_comb begin
    seq_pc  = cur_pc + XLEN'(ILEN);
    ofs_ext = {{EXT_W{br_offset[OFS_W-1]}}, br_offset, {SH{1'b0}}};
    br_pc   = seq_pc + ofs_ext;
    reg_pc  = {reg_word, {SH{1'b0}}};
  end

  generate
    if (RGN_W > 0) begin : g_region
      assign abs_pc = {seq_pc[XLEN-1 -: RGN_W], jmp_field, {SH{1'b0}}};
    end else begin : g_flat
      assign abs_pc = {jmp_field[XLEN-SH-1:0], {SH{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned JMP_W    = 26,
  parameter int unsigned ILEN     = 4,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 insn_valid,
  input  logic [XLEN-1:0]      cur_pc,
  input  logic [CLASS_W-1:0]   ctl_class,
  input  logic [1:0]           cond_sel,
  input  logic [XLEN-1:0]      opnd_a,
  input  logic [XLEN-1:0]      opnd_b,
  input  logic [OFS_W-1:0]     br_offset,
  input  logic [JMP_W-1:0]     jmp_field,
  output logic [XLEN-1:0]      next_pc,
  output logic                 taken
);
  localparam int unsigned SH = $clog2(ILEN);

  // reset synchroniser: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic            is_branch;
  logic            br_take;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] abs_pc;
  logic [XLEN-1:0] reg_pc;

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .ctl_class (ctl_class),
    .cond_sel  (cond_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .is_branch (is_branch),
    .br_take   (br_take)
  );

  nextpc_target #(
    .XLEN(XLEN), .OFS_W(OFS_W), .JMP_W(JMP_W), .ILEN(ILEN)
  ) u_tgt (
    .cur_pc    (cur_pc),
    .br_offset (br_offset),
    .jmp_field (jmp_field),
    .reg_word  (opnd_a[XLEN-1:SH]),
    .seq_pc    (seq_pc),
    .br_pc     (br_pc),
    .abs_pc    (abs_pc),
    .reg_pc    (reg_pc)
  );

  logic [XLEN-1:0] pc_d;
  logic            taken_d;
  logic            upd_en;

  always_comb begin
    upd_en  = insn_valid;
    pc_d    = seq_pc;
    taken_d = 1'b0;
    if (is_branch) begin
      if (br_take) begin
        pc_d    = br_pc;
        taken_d = 1'b1;
      end
    end else if (ctl_class == NPC_JMP_ABS) begin
      pc_d    = abs_pc;
      taken_d = 1'b1;
    end else if (ctl_class == NPC_JMP_REG) begin
      pc_d    = reg_pc;
      taken_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_pc <= RESET_PC[XLEN-1:0];
      taken   <= 1'b0;
    end else if (upd_en) begin
      next_pc <= pc_d;
      taken   <= taken_d;
    end
  end
endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            insn_valid,
  input logic [XLEN-1:0] cur_pc,
  input logic [2:0]      ctl_class,
  input logic [1:0]      cond_sel,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic [XLEN-1:0] next_pc,
  input logic            taken
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !insn_valid |=> ($stable(next_pc) && $stable(taken))); // R9

  AST_SEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn_valid && (ctl_class == 3'd0 || ctl_class > 3'd4))
      |=> (next_pc == $past(cur_pc) + XLEN'(4) && !taken)); // R1

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn_valid && (ctl_class == 3'd3 || ctl_class == 3'd4)) |=> taken); // R5

  AST_REGJ_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn_valid && ctl_class == 3'd4)
      |=> (next_pc[1:0] == 2'b00 && next_pc[XLEN-1:2] == $past(opnd_a[XLEN-1:2]))); // R6

  AST_PAIR_DECIDE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn_valid && ctl_class == 3'd1)
      |=> (taken == ($past(cond_sel[0]) ^ ($past(opnd_a) == $past(opnd_b))))); // R2

  AST_BR_MISS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (insn_valid && (ctl_class == 3'd1 || ctl_class == 3'd2))
      |=> (taken || next_pc == $past(cur_pc) + XLEN'(4))); // R7
endmodule

bind nextpc_unit nextpc_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .insn_valid (insn_valid),
  .cur_pc     (cur_pc),
  .ctl_class  (ctl_class),
  .cond_sel   (cond_sel),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .next_pc    (next_pc),
  .taken      (taken)
);

// File: tb/sim_nextpc_unit.sv
`timescale 1ns/1ps
module sim_nextpc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] cur_pc;
  logic [2:0]  ctl_class;
  logic [1:0]  cond_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [15:0] br_offset;
  logic [25:0] jmp_field;
  logic [31:0] next_pc;
  logic        taken;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  nextpc_unit u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .cur_pc(cur_pc),
    .ctl_class(ctl_class), .cond_sel(cond_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .br_offset(br_offset), .jmp_field(jmp_field),
    .next_pc(next_pc), .taken(taken)
  );

  typedef struct packed {
    logic [2:0]  cls;
    logic [1:0]  cnd;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] ofs;
    logic [25:0] jf;
    logic [31:0] epc;
    logic        etk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'b00, 32'h0000_1000, 32'h0, 32'h0, 16'h0000, 26'h0, 32'h0000_1004, 1'b0, 4'd1},       // R1
    '{3'd1, 2'b00, 32'h0000_1000, 32'd5, 32'd5, 16'h0010, 26'h0, 32'h0000_1044, 1'b1, 4'd2},       // R2 R4 beq hit
    '{3'd1, 2'b00, 32'h0000_1000, 32'd5, 32'd6, 16'h0010, 26'h0, 32'h0000_1004, 1'b0, 4'd7},       // R7 beq miss
    '{3'd1, 2'b01, 32'h0000_2000, 32'd5, 32'd6, 16'hFFFF, 26'h0, 32'h0000_2000, 1'b1, 4'd4},       // R4 negative offset
    '{3'd1, 2'b01, 32'h0000_2000, 32'd7, 32'd7, 16'hFFFF, 26'h0, 32'h0000_2004, 1'b0, 4'd7},       // R7 bne miss
    '{3'd2, 2'b00, 32'h0000_3000, 32'd1, 32'h0, 16'h0002, 26'h0, 32'h0000_300C, 1'b1, 4'd3},       // R3 gtz
    '{3'd2, 2'b00, 32'h0000_3000, 32'd0, 32'h0, 16'h0002, 26'h0, 32'h0000_3004, 1'b0, 4'd3},       // R3 gtz at zero
    '{3'd2, 2'b01, 32'h0000_3000, 32'd0, 32'h0, 16'h0002, 26'h0, 32'h0000_300C, 1'b1, 4'd3},       // R3 gez at zero
    '{3'd2, 2'b01, 32'h0000_3000, 32'h8000_0000, 32'h0, 16'h0002, 26'h0, 32'h0000_3004, 1'b0, 4'd3}, // R3 gez most negative
    '{3'd2, 2'b10, 32'h0004_0000, 32'hFFFF_FFFF, 32'h0, 16'h8000, 26'h0, 32'h0002_0004, 1'b1, 4'd4}, // R4 min offset, R3 ltz
    '{3'd2, 2'b10, 32'h0004_0000, 32'd0, 32'h0, 16'h8000, 26'h0, 32'h0004_0004, 1'b0, 4'd3},       // R3 ltz at zero
    '{3'd2, 2'b11, 32'h0000_0000, 32'd0, 32'h0, 16'h7FFF, 26'h0, 32'h0002_0000, 1'b1, 4'd4},       // R4 max offset, R3 lez
    '{3'd2, 2'b11, 32'h0000_0000, 32'd1, 32'h0, 16'h7FFF, 26'h0, 32'h0000_0004, 1'b0, 4'd3},       // R3 lez positive
    '{3'd3, 2'b00, 32'hA000_1000, 32'h0, 32'h0, 16'h0, 26'h3FF_FFFF, 32'hAFFF_FFFC, 1'b1, 4'd5},  // R5
    '{3'd3, 2'b00, 32'h1FFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h000_0010, 32'h2000_0040, 1'b1, 4'd5},  // R5 region from PC+4
    '{3'd4, 2'b00, 32'h0000_0100, 32'h1234_5677, 32'h0, 16'h0, 26'h0, 32'h1234_5674, 1'b1, 4'd6}, // R6
    '{3'd7, 2'b00, 32'h0000_0500, 32'h0, 32'h0, 16'h0010, 26'h0, 32'h0000_0504, 1'b0, 4'd1},       // R1 undefined class
    '{3'd1, 2'b10, 32'h0000_0000, 32'd9, 32'd9, 16'h0001, 26'h0, 32'h0000_0008, 1'b1, 4'd2},       // R2 bit1 ignored
    '{3'd0, 2'b00, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0000_0000, 1'b0, 4'd1}          // R1 wrap
  };

  task automatic check(input string tag, input logic [31:0] epc, input logic etk);
    checks++;
    if (next_pc !== epc || taken !== etk) begin
      errors++;
      $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
               tag, next_pc, taken, epc, etk);
    end
  endtask

  task automatic drive(input vec_t v);
    ctl_class = v.cls;  cond_sel = v.cnd;  cur_pc = v.pc;
    opnd_a = v.a;  opnd_b = v.b;  br_offset = v.ofs;  jmp_field = v.jf;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    drive(v);
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_valid = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check("R8 reset value", 32'h0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 after release", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].epc, VEC[i].etk);
    end

    // R9: outputs hold while the strobe is low
    apply(VEC[13]);
    check("R5 before hold", 32'hAFFF_FFFC, 1'b1);
    @(negedge clk);
    drive(VEC[2]);
    repeat (3) @(negedge clk);
    check("R9 hold with strobe low", 32'hAFFF_FFFC, 1'b1);

    // R9: one strobe updates exactly once, on its edge
    apply(VEC[15]);
    check("R9 single strobe update", 32'h1234_5674, 1'b1);

    // R8: mid-run reset clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear mid-run", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 held through sync release", 32'h0, 1'b0);
    repeat (3) @(negedge clk);
    apply(VEC[1]);
    check("R2 after reset", 32'h0000_1044, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule